// File: doc/BRIEF.md
# Control Register File with Fault Capture

This block holds a small set of processor control registers. Software reaches them through one access port made of a register index, an access strobe, a write-enable, write data and combinational read data. A hardware side input loads the faulting linear address into the fault register when a translation fault is reported. The block also drives three derived outputs: a paging-enable flag, a page-table base address and a process-context identifier.

The index space has eight slots. Slots 0, 2, 3 and 4 are implemented. Slots 1, 5, 6 and 7 are reserved. An access to a reserved slot raises an undefined-operation flag in the same cycle and changes no state. Storage is 64 bits wide. While the long-mode input is low, the block behaves as a 32-bit register file: writes and fault captures keep only the low 32 bits, and reads and derived outputs are masked to 32 bits.

The block has no sequencing state machine. Its only states are the values held in the registers. Each register has two transitions: reset to zero, and load on the next rising clock edge, taken by a software write or by a fault capture.

Top module: `ctrl_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every implemented register reads as zero, and `pg_en`, `pt_base` and `ctx_id` are zero.
- R2: An access (`acc_en`=1) to index 1, 5, 6 or 7 drives `exc_ud` high in the same cycle, drives `rdata` to zero and leaves all registers unchanged. An access to index 0, 2, 3 or 4 keeps `exc_ud` low.
- R3: With `acc_en`=1 and `wr_en`=1, `wdata` is stored into the indexed register at the next rising edge. With `acc_en`=1 and `wr_en`=0, `rdata` shows that register combinationally in the same cycle.
- R4: With `long_mode`=0, a write stores the low 32 bits of `wdata` zero-extended, a fault capture stores the low 32 bits of `flt_addr`, and `rdata` and `pt_base` have bits 63..32 forced to zero.
- R5: When `flt_vld`=1 at a rising edge, register 2 holds `flt_addr` after that edge.
- R6: If `flt_vld` and a software write to register 2 fall in the same cycle, register 2 takes the fault address and the write data is dropped.
- R7: `pg_en` equals bit 31 of register 0. While `pg_en`=1, `pt_base` equals register 3 with bits 11..0 cleared, masked to the active width. While `pg_en`=0, `pt_base` is zero.
- R8: While bit 17 of register 4 is 1, `ctx_id` equals bits 11..0 of register 3. While that bit is 0, `ctx_id` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| long_mode | input | 1 | 1 selects 64-bit width, 0 selects 32-bit width |
| acc_en | input | 1 | Access strobe for the software port |
| wr_en | input | 1 | Write when high during an access, read when low |
| idx | input | 3 | Register index |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data of the indexed register, valid in the same cycle |
| exc_ud | output | 1 | Undefined-operation flag for an access to a reserved index |
| flt_vld | input | 1 | Translation-fault strobe |
| flt_addr | input | 64 | Faulting linear address |
| pg_en | output | 1 | Paging enable, bit 31 of register 0 |
| pt_base | output | 64 | Page-table base address, gated by paging enable |
| ctx_id | output | 12 | Process-context identifier, gated by bit 17 of register 4 |

## Verification
The bench writes data into reserved indices and then reads back every implemented register. A design that decoded a reserved slot as an alias of a real one would show the written value there. The bench drives a fault strobe and a software write to register 2 in the same cycle, where a design with the wrong priority would read back the write data. It also performs writes and fault captures in 32-bit mode and reads them in 64-bit mode, which exposes upper bits that were kept when they should have been dropped. Finally it toggles the context-ID enable bit and the paging bit, which catches a `ctx_id` or `pt_base` that stays stuck at its last value.

// File: rtl/ctrl_regfile_pkg.sv
package ctrl_regfile_pkg;

    localparam int IDX_W   = 3;
    localparam int NREG    = 4;
    localparam int LEG_W   = 32;
    localparam int PG_BIT  = 31;
    localparam int CTXE_BIT = 17;

    typedef enum logic [IDX_W-1:0] {
        IDX_MODE  = 3'd0,
        IDX_FAULT = 3'd2,
        IDX_BASE  = 3'd3,
        IDX_FEAT  = 3'd4
    } reg_idx_e;

    localparam int SLOT_MODE  = 0;
    localparam int SLOT_FAULT = 1;
    localparam int SLOT_BASE  = 2;
    localparam int SLOT_FEAT  = 3;

endpackage

// File: rtl/ctrl_idx_decode.sv
module ctrl_idx_decode
    import ctrl_regfile_pkg::*;
(
    input  logic             acc_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  rsel,
    output logic [NREG-1:0]  wsel,
    output logic             rsv_hit
);

    logic [NREG-1:0] hit;

    always_comb begin
        hit = '0;
        unique case (idx)
            IDX_MODE:  hit[SLOT_MODE]  = 1'b1;
            IDX_FAULT: hit[SLOT_FAULT] = 1'b1;
            IDX_BASE:  hit[SLOT_BASE]  = 1'b1;
            IDX_FEAT:  hit[SLOT_FEAT]  = 1'b1;
            default:   hit = '0;
        endcase
    end

    assign rsel    = acc_en ? hit : '0;
    assign wsel    = (acc_en && wr_en) ? hit : '0;
    assign rsv_hit = acc_en && (hit == '0);

    // R2
    sel_exclusive_chk: assert final (!(rsv_hit && (|rsel)) && $onehot0(rsel));

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import ctrl_regfile_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] wsel,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] mask,
    input  logic            flt_vld,
    input  logic [XLEN-1:0] flt_addr,
    output logic [XLEN-1:0] regs [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] nxt;
        logic            ld;

        if (g == SLOT_FAULT) begin : g_flt
            always_comb begin
                ld  = flt_vld || wsel[g];
                nxt = (flt_vld ? flt_addr : wdata) & mask;
            end
        end else begin : g_sw
            always_comb begin
                ld  = wsel[g];
                nxt = wdata & mask;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (ld)
                regs[g] <= nxt;
        end
    end

    // R5
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_vld |=> regs[SLOT_FAULT] == $past(flt_addr & mask));

    // R4
    legacy_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel[SLOT_BASE] && (mask[XLEN-1] == 1'b0))
            |=> regs[SLOT_BASE][XLEN-1:LEG_W] == '0);

endmodule

// File: rtl/ctrl_derive.sv
module ctrl_derive #(
    parameter int XLEN  = 64,
    parameter int CTX_W = 12
) (
    input  logic             rst_n,
    input  logic             clk,
    input  logic             pg_bit,
    input  logic             ctxe_bit,
    input  logic [XLEN-1:0]  base_reg,
    input  logic [XLEN-1:0]  mask,
    output logic             pg_en,
    output logic [XLEN-1:0]  pt_base,
    output logic [CTX_W-1:0] ctx_id
);

    localparam logic [XLEN-1:0] LOW_CLR = ~{{(XLEN-CTX_W){1'b0}}, {CTX_W{1'b1}}};

    always_comb begin
        pg_en   = pg_bit;
        pt_base = pg_bit ? (base_reg & mask & LOW_CLR) : '0;
        ctx_id  = ctxe_bit ? base_reg[CTX_W-1:0] : '0;
    end

    // R8
    ctx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_id != '0) |-> ctxe_bit);

    // R7
    base_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_base != '0) |-> (pg_en && pt_base[CTX_W-1:0] == '0));

endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
    import ctrl_regfile_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CTX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_mode,
    input  logic             acc_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata,
    output logic             exc_ud,
    input  logic             flt_vld,
    input  logic [XLEN-1:0]  flt_addr,
    output logic             pg_en,
    output logic [XLEN-1:0]  pt_base,
    output logic [CTX_W-1:0] ctx_id
);

    localparam logic [XLEN-1:0] LEG_MASK = {{(XLEN-LEG_W){1'b0}}, {LEG_W{1'b1}}};

    logic [NREG-1:0] rsel;
    logic [NREG-1:0] wsel;
    logic            rsv_hit;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] regs [NREG];

    assign mask = long_mode ? '1 : LEG_MASK;

    ctrl_idx_decode u_dec (
        .acc_en  (acc_en),
        .wr_en   (wr_en),
        .idx     (idx),
        .rsel    (rsel),
        .wsel    (wsel),
        .rsv_hit (rsv_hit)
    );

    ctrl_reg_bank #(.XLEN(XLEN)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wsel     (wsel),
        .wdata    (wdata),
        .mask     (mask),
        .flt_vld  (flt_vld),
        .flt_addr (flt_addr),
        .regs     (regs)
    );

    ctrl_derive #(.XLEN(XLEN), .CTX_W(CTX_W)) u_drv (
        .rst_n    (rst_n),
        .clk      (clk),
        .pg_bit   (regs[SLOT_MODE][PG_BIT]),
        .ctxe_bit (regs[SLOT_FEAT][CTXE_BIT]),
        .base_reg (regs[SLOT_BASE]),
        .mask     (mask),
        .pg_en    (pg_en),
        .pt_base  (pt_base),
        .ctx_id   (ctx_id)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (rsel[i])
                rdata = rdata | regs[i];
        rdata  = rdata & mask;
        exc_ud = rsv_hit;
    end

    // R2
    rsv_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ud && wr_en && !flt_vld) |=>
            ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2]) && $stable(regs[3])));

    // R2
    rsv_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ud |-> rdata == '0);

    // R6
    fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_vld && acc_en && wr_en && idx == 3'd2) |=> regs[1] == $past(flt_addr & mask));

endmodule

// File: tb/ctrl_regfile_tb.sv
module ctrl_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_mode = 1'b1;
    logic        acc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  idx = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        exc_ud;
    logic        flt_vld = 1'b0;
    logic [63:0] flt_addr = '0;
    logic        pg_en;
    logic [63:0] pt_base;
    logic [11:0] ctx_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .acc_en(acc_en),
        .wr_en(wr_en), .idx(idx), .wdata(wdata), .rdata(rdata), .exc_ud(exc_ud),
        .flt_vld(flt_vld), .flt_addr(flt_addr), .pg_en(pg_en),
        .pt_base(pt_base), .ctx_id(ctx_id)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  ix;
        logic        lm;
        logic [63:0] dat;
        logic        exc;
        logic [63:0] expv;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 1'b1, 64'h0000_0000_8000_0001, 1'b0, 64'h0},
        '{1'b0, 3'd0, 1'b1, 64'h0, 1'b0, 64'h0000_0000_8000_0001},
        '{1'b1, 3'd3, 1'b1, 64'h0000_0001_2345_6ABC, 1'b0, 64'h0},
        '{1'b0, 3'd3, 1'b1, 64'h0, 1'b0, 64'h0000_0001_2345_6ABC},
        '{1'b1, 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0},
        '{1'b0, 3'd1, 1'b1, 64'h0, 1'b1, 64'h0},
        '{1'b1, 3'd5, 1'b1, 64'h5555_5555_5555_5555, 1'b1, 64'h0},
        '{1'b0, 3'd6, 1'b1, 64'h0, 1'b1, 64'h0},
        '{1'b1, 3'd7, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 64'h0},
        '{1'b1, 3'd4, 1'b1, 64'h0000_0000_0002_0000, 1'b0, 64'h0},
        '{1'b0, 3'd4, 1'b1, 64'h0, 1'b0, 64'h0000_0000_0002_0000},
        '{1'b1, 3'd2, 1'b1, 64'hDEAD_BEEF_0000_1000, 1'b0, 64'h0},
        '{1'b0, 3'd2, 1'b1, 64'h0, 1'b0, 64'hDEAD_BEEF_0000_1000},
        '{1'b1, 3'd2, 1'b0, 64'hFFFF_FFFF_1234_5678, 1'b0, 64'h0},
        '{1'b0, 3'd2, 1'b1, 64'h0, 1'b0, 64'h0000_0000_1234_5678},
        '{1'b0, 3'd0, 1'b1, 64'h0, 1'b0, 64'h0000_0000_8000_0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en = 1'b0; wr_en = 1'b0; flt_vld = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [2:0] i, input logic [63:0] d, input logic lm,
                      input logic exc_exp, input string req);
        @(negedge clk);
        acc_en = 1'b1; wr_en = 1'b1; idx = i; wdata = d; long_mode = lm;
        #1;
        chk(req, {63'd0, exc_ud}, {63'd0, exc_exp});
    endtask

    task automatic rd(input logic [2:0] i, input logic lm, input logic [63:0] expv,
                      input string req);
        @(negedge clk);
        acc_en = 1'b1; wr_en = 1'b0; idx = i; long_mode = lm; flt_vld = 1'b0;
        #1;
        chk(req, rdata, expv);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pg_en in reset", {63'd0, pg_en}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd0, 1'b1, 64'd0, "R1 reg0 after reset");
        rd(3'd2, 1'b1, 64'd0, "R1 reg2 after reset");
        rd(3'd3, 1'b1, 64'd0, "R1 reg3 after reset");
        rd(3'd4, 1'b1, 64'd0, "R1 reg4 after reset");
        chk("R1 pt_base after reset", pt_base, 64'd0);
        chk("R1 ctx_id after reset", {52'd0, ctx_id}, 64'd0);

        // R2 R3 R4: table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            acc_en = 1'b1; wr_en = VECS[v].wr; idx = VECS[v].ix;
            wdata = VECS[v].dat; long_mode = VECS[v].lm;
            #1;
            chk($sformatf("R2 exc row %0d", v), {63'd0, exc_ud}, {63'd0, VECS[v].exc});
            if (!VECS[v].wr)
                chk($sformatf("R3 rdata row %0d", v), rdata, VECS[v].expv);
        end
        idle();

        // R2: reserved writes left other registers intact
        rd(3'd3, 1'b1, 64'h0000_0001_2345_6ABC, "R2 reg3 intact");
        rd(3'd4, 1'b1, 64'h0000_0000_0002_0000, "R2 reg4 intact");
        idle();

        // R7 R8: derived outputs
        chk("R7 pg_en set", {63'd0, pg_en}, 64'd1);
        chk("R7 pt_base long", pt_base, 64'h0000_0001_2345_6000);
        chk("R8 ctx_id enabled", {52'd0, ctx_id}, 64'h0ABC);
        @(negedge clk); long_mode = 1'b0; #1;
        chk("R4 pt_base legacy", pt_base, 64'h0000_0000_2345_6000);
        rd(3'd3, 1'b0, 64'h0000_0000_2345_6ABC, "R4 rdata legacy mask");

        wr(3'd4, 64'd0, 1'b1, 1'b0, "R8 clear enable exc");
        idle();
        chk("R8 ctx_id off", {52'd0, ctx_id}, 64'd0);
        wr(3'd4, 64'h0002_0000, 1'b1, 1'b0, "R8 set enable exc");
        idle();
        chk("R8 ctx_id back on", {52'd0, ctx_id}, 64'h0ABC);

        wr(3'd0, 64'd1, 1'b1, 1'b0, "R7 clear pg exc");
        idle();
        chk("R7 pg_en clear", {63'd0, pg_en}, 64'd0);
        chk("R7 pt_base gated", pt_base, 64'd0);
        chk("R8 ctx_id independent of pg", {52'd0, ctx_id}, 64'h0ABC);

        // R5: fault capture
        @(negedge clk);
        acc_en = 1'b0; long_mode = 1'b1; flt_vld = 1'b1; flt_addr = 64'hCAFE_F00D_1234_0000;
        rd(3'd2, 1'b1, 64'hCAFE_F00D_1234_0000, "R5 fault latched");

        // R6: fault beats simultaneous write
        wr(3'd2, 64'h0000_0000_0000_1111, 1'b1, 1'b0, "R6 write exc");
        flt_vld = 1'b1; flt_addr = 64'h0000_0000_0BAD_F000;
        rd(3'd2, 1'b1, 64'h0000_0000_0BAD_F000, "R6 fault wins");

        // R4: fault in legacy width
        @(negedge clk);
        acc_en = 1'b0; long_mode = 1'b0; flt_vld = 1'b1; flt_addr = 64'hFFFF_0000_8765_4321;
        rd(3'd2, 1'b1, 64'h0000_0000_8765_4321, "R4 legacy fault trimmed");
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule